// File: doc/BRIEF.md
# Link Failover Sequencing Controller

This controller moves a pair of serial links (an upstream link and a bridge link) between pass-through and swapped lane routing while the rest of the system keeps running. Three independent agents can ask for a routing change: a decoded software register write, an external pin, and a watchdog timer. Each request is a one-cycle pulse. Competing requests are ordered, and each accepted request runs one full change sequence.

A sequence has four steps. First both links are forced back to detection, data-link-down is driven, and the replay buffers are told to drop their contents. Next the routing select flips. Then one training-start pulse goes out. Finally the controller waits until both links report up, or until a programmable number of cycles has passed. Link-event interrupts are masked for the whole sequence.

A four-bit status word reports the current routing mode and three sticky flags: sequence started, sequence finished, and retrain timeout. Software clears the flags by writing ones. Only the fundamental reset clears the flags or abandons a running sequence. A hot reset is not wired to this block, so it leaves both untouched. When the fundamental reset releases, the mode is reloaded from the boot-mode pin.

Top module: `fovr_seq_ctrl`

## Requirements
- R1: While `fund_rst` is high, and in the cycle after it falls, `status` reads `{boot_mode,3'b000}`, all link control outputs are low and `active_src` is 3 (idle).
- R2: A request accepted in idle starts a sequence at the next clock edge. For the first two cycles `link_to_detect` and `dl_down` are high. `replay_discard` is high for the first cycle only. Status bit 0 (started) becomes 1 in the first cycle.
- R3: `route_swap` and status bit 3 (1 = swapped) invert exactly once per sequence, in the third cycle of the sequence, and never change while idle.
- R4: `train_start` is a single-cycle pulse in the third cycle of the sequence, together with the new routing value.
- R5: From the fourth cycle on, the sequence ends in the first cycle in which `up_link_up` and `br_link_up` are both high. At that edge, status bit 1 (finished) becomes 1.
- R6: If the links are not both up, the sequence ends after `retrain_tmo`+1 waiting cycles. Both status bit 1 and status bit 2 (timeout error) are then set.
- R7: A request from the same source as the running sequence is discarded.
- R8: A request from a different source during a sequence is kept and served after the sequence ends. When several are waiting, they are served in the order software (`active_src`=0), signal (1), watchdog (2), one sequence each.
- R9: `link_evt_mask` is high exactly while a sequence is running (all four steps).
- R10: A cycle with `stat_wr` high clears each flag whose bit is 1 in `stat_wr_data` (bit 0 started, bit 1 finished, bit 2 error). Several flags can be cleared at once. A flag being set in the same cycle wins over the clear.
- R11: Asserting `fund_rst` during a sequence abandons it: the controller returns to idle, clears pending requests, and reloads the mode from `boot_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst | input | 1 | Fundamental reset, synchronous, active high |
| boot_mode | input | 1 | Routing mode loaded at reset (1 = swapped) |
| sw_req | input | 1 | Software request pulse |
| sig_req | input | 1 | External signal request pulse |
| wdt_req | input | 1 | Watchdog request pulse |
| retrain_tmo | input | TMO_W | Retrain wait limit in cycles |
| up_link_up | input | 1 | Upstream link reports up |
| br_link_up | input | 1 | Bridge link reports up |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_data | input | 3 | Write-one-to-clear flag bits |
| link_to_detect | output | 1 | Force both links back to detection |
| dl_down | output | 1 | Data link down indication |
| replay_discard | output | 1 | Replay buffer drop strobe |
| route_swap | output | 1 | Lane routing select (1 = swapped) |
| train_start | output | 1 | Start link training pulse |
| link_evt_mask | output | 1 | Mask link up/down interrupt events |
| active_src | output | 2 | Source of running sequence, 3 when idle |
| status | output | 4 | {mode, error, finished, started} |

## Verification
The main function is tried with a single request whose links recover, a single request whose links stay down until the timeout, a repeat of the running source within a sequence, requests from other sources arriving during a sequence, and all three requests arriving in the same idle cycle. The recovery and timeout runs separate the two ways a sequence can end and the error flag. The repeat and mid-sequence cases separate discarding from queueing. The simultaneous burst, read through the reported source, shows the fixed service order. Clear writes with mixed bit masks, a clear that lands on a start edge, and a fundamental reset during retraining cover the status flags and abort behaviour.

// File: rtl/fovr_pkg.sv
package fovr_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DOWN  = 3'd1,
        ST_ROUTE = 3'd2,
        ST_TRAIN = 3'd3,
        ST_WAIT  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_SIG  = 2'd1,
        SRC_WDT  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic mode;
        logic err;
        logic done;
        logic init;
    } stat_t;

    // lowest index wins: software first, then signal, then watchdog
    function automatic logic [NUM_SRC-1:0] pick_first(input logic [NUM_SRC-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    function automatic src_e oh_to_src(input logic [NUM_SRC-1:0] oh);
        src_e r;
        r = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (oh[i]) r = src_e'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/fovr_req_arb.sv
module fovr_req_arb
    import fovr_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic            busy,
    input  logic [NSRC-1:0] run_oh,
    output logic [NSRC-1:0] gnt
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] accepted;
    logic [NSRC-1:0] cand;

    // a repeat of the running source is dropped, others are kept
    assign accepted = req & ~run_oh;
    assign cand     = pend_q | accepted;
    assign gnt      = busy ? '0 : pick_first(cand);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= cand & ~gnt;
        end
    end
endmodule

// File: rtl/fovr_seq_fsm.sv
module fovr_seq_fsm
    import fovr_pkg::*;
#(
    parameter int NSRC  = NUM_SRC,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  gnt,
    input  logic             both_up,
    input  logic [TMO_W-1:0] tmo,
    output seq_state_e       state,
    output logic [NSRC-1:0]  run_oh,
    output logic             start_p,
    output logic             flip_p,
    output logic             done_p,
    output logic             err_p
);
    seq_state_e      st_q, st_d;
    logic [NSRC-1:0] run_q;
    logic [TMO_W-1:0] cnt_q;
    logic            expired;

    assign expired = (cnt_q >= tmo);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (|gnt) st_d = ST_DOWN;
            ST_DOWN:  st_d = ST_ROUTE;
            ST_ROUTE: st_d = ST_TRAIN;
            ST_TRAIN: st_d = ST_WAIT;
            ST_WAIT:  if (both_up || expired) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            run_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) begin
                run_q <= gnt;
            end else if (st_d == ST_IDLE) begin
                run_q <= '0;
            end
            if (st_q != ST_WAIT) begin
                cnt_q <= '0;
            end else if (!expired) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state   = st_q;
    assign run_oh  = run_q;
    assign start_p = (st_q == ST_IDLE) && (|gnt);
    assign flip_p  = (st_q == ST_ROUTE);
    assign done_p  = (st_q == ST_WAIT) && (both_up || expired);
    assign err_p   = (st_q == ST_WAIT) && !both_up && expired;
endmodule

// File: rtl/fovr_status.sv
module fovr_status
    import fovr_pkg::*;
#(
    parameter int FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    input  logic              start_p,
    input  logic              flip_p,
    input  logic              done_p,
    input  logic              err_p,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_bits,
    output stat_t             stat
);
    stat_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= boot_mode;
            st_q.err  <= 1'b0;
            st_q.done <= 1'b0;
            st_q.init <= 1'b0;
        end else begin
            if (clr_en) begin
                if (clr_bits[0]) st_q.init <= 1'b0;
                if (clr_bits[1]) st_q.done <= 1'b0;
                if (clr_bits[2]) st_q.err  <= 1'b0;
            end
            // set events override a clear in the same cycle
            if (start_p) st_q.init <= 1'b1;
            if (done_p)  st_q.done <= 1'b1;
            if (err_p)   st_q.err  <= 1'b1;
            if (flip_p)  st_q.mode <= ~st_q.mode;
        end
    end

    assign stat = st_q;
endmodule

// File: rtl/fovr_seq_ctrl.sv
module fovr_seq_ctrl
    import fovr_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             fund_rst,
    input  logic             boot_mode,
    input  logic             sw_req,
    input  logic             sig_req,
    input  logic             wdt_req,
    input  logic [TMO_W-1:0] retrain_tmo,
    input  logic             up_link_up,
    input  logic             br_link_up,
    input  logic             stat_wr,
    input  logic [2:0]       stat_wr_data,
    output logic             link_to_detect,
    output logic             dl_down,
    output logic             replay_discard,
    output logic             route_swap,
    output logic             train_start,
    output logic             link_evt_mask,
    output logic [1:0]       active_src,
    output logic [3:0]       status
);
    localparam int NSRC = NUM_SRC;

    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] gnt;
    logic [NSRC-1:0] run_oh;
    seq_state_e      state;
    logic            busy;
    logic            start_p, flip_p, done_p, err_p;
    stat_t           stat;

    assign req_vec = {wdt_req, sig_req, sw_req};
    assign busy    = (state != ST_IDLE);

    fovr_req_arb #(.NSRC(NSRC)) u_arb (
        .clk    (clk),
        .rst    (fund_rst),
        .req    (req_vec),
        .busy   (busy),
        .run_oh (run_oh),
        .gnt    (gnt)
    );

    fovr_seq_fsm #(.NSRC(NSRC), .TMO_W(TMO_W)) u_fsm (
        .clk     (clk),
        .rst     (fund_rst),
        .gnt     (gnt),
        .both_up (up_link_up && br_link_up),
        .tmo     (retrain_tmo),
        .state   (state),
        .run_oh  (run_oh),
        .start_p (start_p),
        .flip_p  (flip_p),
        .done_p  (done_p),
        .err_p   (err_p)
    );

    fovr_status #(.FLAG_W(3)) u_stat (
        .clk       (clk),
        .rst       (fund_rst),
        .boot_mode (boot_mode),
        .start_p   (start_p),
        .flip_p    (flip_p),
        .done_p    (done_p),
        .err_p     (err_p),
        .clr_en    (stat_wr),
        .clr_bits  (stat_wr_data),
        .stat      (stat)
    );

    assign link_to_detect = (state == ST_DOWN) || (state == ST_ROUTE);
    assign dl_down        = link_to_detect;
    assign replay_discard = (state == ST_DOWN);
    assign train_start    = (state == ST_TRAIN);
    assign link_evt_mask  = busy;
    assign route_swap     = stat.mode;
    assign active_src     = oh_to_src(run_oh);
    assign status         = stat;
endmodule

// File: rtl/fovr_seq_chk.sv
module fovr_seq_chk (
    input logic       clk,
    input logic       fund_rst,
    input logic       link_to_detect,
    input logic       replay_discard,
    input logic       train_start,
    input logic       link_evt_mask,
    input logic       route_swap,
    input logic [1:0] active_src,
    input logic [3:0] status
);
    a_r2_discard_single: assert property (@(posedge clk) disable iff (fund_rst)
        replay_discard |=> !replay_discard);

    a_r2_started_flag: assert property (@(posedge clk) disable iff (fund_rst)
        $rose(link_to_detect) |-> status[0]);

    a_r4_train_single: assert property (@(posedge clk) disable iff (fund_rst)
        train_start |=> !train_start);

    a_r3_mode_only_in_seq: assert property (@(posedge clk) disable iff (fund_rst)
        !$stable(route_swap) |-> train_start);

    a_r9_mask_covers: assert property (@(posedge clk) disable iff (fund_rst)
        (link_to_detect || train_start) |-> link_evt_mask);

    a_r6_err_with_done: assert property (@(posedge clk) disable iff (fund_rst)
        $rose(status[2]) |-> status[1]);

    a_r8_src_tracks_seq: assert property (@(posedge clk) disable iff (fund_rst)
        link_evt_mask == (active_src != 2'd3));
endmodule

bind fovr_seq_ctrl fovr_seq_chk u_chk (
    .clk            (clk),
    .fund_rst       (fund_rst),
    .link_to_detect (link_to_detect),
    .replay_discard (replay_discard),
    .train_start    (train_start),
    .link_evt_mask  (link_evt_mask),
    .route_swap     (route_swap),
    .active_src     (active_src),
    .status         (status)
);

// File: tb/tb_fovr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_fovr_seq_ctrl;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             fund_rst = 1'b1;
    logic             boot_mode = 1'b1;
    logic             sw_req = 1'b0, sig_req = 1'b0, wdt_req = 1'b0;
    logic [TMO_W-1:0] tmo = 8'd20;
    logic             up_link_up = 1'b0, br_link_up = 1'b0;
    logic             stat_wr = 1'b0;
    logic [2:0]       stat_wr_data = 3'b000;
    logic             link_to_detect, dl_down, replay_discard, route_swap;
    logic             train_start, link_evt_mask;
    logic [1:0]       active_src;
    logic [3:0]       status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit armed = 1'b0;

    always #5 clk = ~clk;

    fovr_seq_ctrl #(.TMO_W(TMO_W)) dut (
        .clk(clk), .fund_rst(fund_rst), .boot_mode(boot_mode),
        .sw_req(sw_req), .sig_req(sig_req), .wdt_req(wdt_req),
        .retrain_tmo(tmo), .up_link_up(up_link_up), .br_link_up(br_link_up),
        .stat_wr(stat_wr), .stat_wr_data(stat_wr_data),
        .link_to_detect(link_to_detect), .dl_down(dl_down),
        .replay_discard(replay_discard), .route_swap(route_swap),
        .train_start(train_start), .link_evt_mask(link_evt_mask),
        .active_src(active_src), .status(status)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_ph = 0;      // 0 idle, 1 down, 2 route, 3 train, 4 wait
    int       m_src = 3;
    int       m_cnt = 0;
    bit [2:0] m_pend = '0;
    bit [2:0] m_rq, m_cand;
    bit       m_mode = 1'b0, m_fi = 1'b0, m_fc = 1'b0, m_fe = 1'b0;

    always @(posedge clk) begin
        m_rq = {wdt_req, sig_req, sw_req};
        if (fund_rst) begin
            m_ph = 0; m_src = 3; m_cnt = 0; m_pend = '0;
            m_mode = boot_mode; m_fi = 0; m_fc = 0; m_fe = 0;
        end else begin
            if (stat_wr) begin
                if (stat_wr_data[0]) m_fi = 0;
                if (stat_wr_data[1]) m_fc = 0;
                if (stat_wr_data[2]) m_fe = 0;
            end
            if (m_ph == 0) begin
                m_cand = m_pend | m_rq;
                m_src = 3;
                for (int i = 0; i < 3; i++) if (m_cand[i] && m_src == 3) m_src = i;
                if (m_src != 3) begin
                    m_cand[m_src] = 1'b0;
                    m_ph = 1;
                    m_fi = 1;
                end
                m_pend = m_cand;
            end else begin
                for (int i = 0; i < 3; i++) if (m_rq[i] && i != m_src) m_pend[i] = 1'b1;
                case (m_ph)
                    1: m_ph = 2;
                    2: begin m_ph = 3; m_mode = !m_mode; end
                    3: begin m_ph = 4; m_cnt = 0; end
                    default: begin
                        if (up_link_up && br_link_up) begin
                            m_ph = 0; m_fc = 1; m_src = 3;
                        end else if (m_cnt >= int'(tmo)) begin
                            m_ph = 0; m_fc = 1; m_fe = 1; m_src = 3;
                        end else begin
                            m_cnt++;
                        end
                    end
                endcase
            end
        end
        armed = 1'b1;
    end

    int obs_seqs = 0;
    bit prev_disc = 1'b0;

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && !finished) begin
            check("R2 link_to_detect", int'(link_to_detect), int'(m_ph == 1 || m_ph == 2));
            check("R2 dl_down", int'(dl_down), int'(m_ph == 1 || m_ph == 2));
            check("R2 replay_discard", int'(replay_discard), int'(m_ph == 1));
            check("R2 started flag", int'(status[0]), int'(m_fi));
            check("R3 route_swap", int'(route_swap), int'(m_mode));
            check("R3 status mode", int'(status[3]), int'(m_mode));
            check("R4 train_start", int'(train_start), int'(m_ph == 3));
            check("R5 finished flag", int'(status[1]), int'(m_fc));
            check("R6 error flag", int'(status[2]), int'(m_fe));
            check("R9 link_evt_mask", int'(link_evt_mask), int'(m_ph != 0));
            check("R8 active_src", int'(active_src), m_src);
            if (replay_discard && !prev_disc) obs_seqs++;
            prev_disc = replay_discard;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pulse(input bit s, input bit g, input bit w);
        sw_req = s; sig_req = g; wdt_req = w;
        step();
        sw_req = 0; sig_req = 0; wdt_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!link_evt_mask) break;
            step();
        end
    endtask

    task automatic clr(input logic [2:0] bits);
        stat_wr = 1'b1; stat_wr_data = bits;
        step();
        stat_wr = 1'b0; stat_wr_data = 3'b000;
    endtask

    initial begin
        int base;
        // R1: reset with boot pin selecting swapped routing
        step(3);
        check("R1 reset status", int'(status), 8);
        check("R1 reset mask", int'(link_evt_mask), 0);
        fund_rst = 1'b0;
        step();
        check("R1 status after release", int'(status), 8);
        check("R1 idle src", int'(active_src), 3);

        // R2..R5: software request, links recover after a few cycles
        pulse(1, 0, 0);
        check("R2 discard in first cycle", int'(replay_discard), 1);
        step(5);
        up_link_up = 1; br_link_up = 1;
        wait_idle();
        check("R5 status after recovery", int'(status), 4'b0011);

        // R10: clear two flags in one write
        clr(3'b011);
        check("R10 multi-bit clear", int'(status), 4'b0000);

        // R6: timeout with links held down
        tmo = 8'd5;
        up_link_up = 0; br_link_up = 0;
        pulse(0, 0, 1);
        step(14);
        check("R6 status after timeout", int'(status), 4'b1111);
        check("R6 idle after timeout", int'(link_evt_mask), 0);
        up_link_up = 1; br_link_up = 1;

        // R10: clear only the error bit, then the rest
        clr(3'b100);
        check("R10 single clear", int'(status), 4'b1011);
        clr(3'b011);
        check("R10 second clear", int'(status), 4'b1000);

        // R10: clear landing on a start edge loses to the set
        stat_wr = 1'b1; stat_wr_data = 3'b001;
        pulse(1, 0, 0);
        stat_wr = 1'b0; stat_wr_data = 3'b000;
        check("R10 set wins over clear", int'(status[0]), 1);
        wait_idle();

        // R7: repeat of the running source is dropped
        base = obs_seqs;
        pulse(1, 0, 0);
        step();
        pulse(1, 0, 0);
        wait_idle();
        step(3);
        check("R7 duplicate dropped", obs_seqs - base, 1);

        // R8: other sources during a sequence are queued
        base = obs_seqs;
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        pulse(0, 1, 0);
        wait_idle();
        step();
        check("R8 queued next src is signal", int'(active_src), 1);
        wait_idle(); step();
        check("R8 queued last src is watchdog", int'(active_src), 2);
        wait_idle(); step(3);
        check("R8 queued count", obs_seqs - base, 3);

        // R8: all three in one idle cycle
        base = obs_seqs;
        pulse(1, 1, 1);
        check("R8 first served software", int'(active_src), 0);
        wait_idle(); step();
        check("R8 second served signal", int'(active_src), 1);
        wait_idle(); step();
        check("R8 third served watchdog", int'(active_src), 2);
        wait_idle(); step(3);
        check("R8 burst count", obs_seqs - base, 3);

        // R11: fundamental reset abandons a running sequence
        tmo = 8'd50;
        up_link_up = 0; br_link_up = 0;
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        step(3);
        boot_mode = 1'b0;
        fund_rst = 1'b1;
        step(2);
        fund_rst = 1'b0;
        step();
        check("R11 idle after abort", int'(link_evt_mask), 0);
        check("R11 status after abort", int'(status), 0);
        step(4);
        check("R11 pending dropped", int'(link_evt_mask), 0);
        up_link_up = 1; br_link_up = 1;
        step(2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule